// File: doc/BRIEF.md
# Cluster Command Port with Global Cycle Counter

A single command port shared by every core of a multi-core cluster. A core writes a packed command word (operation code plus a 16-bit argument) to the command address and tags the write with its own core number. The block then performs the service and, for commands that return something, loads the result into the readback register. Services provided: reads of a cluster-wide 64-bit cycle counter (low or high half), hardware semaphores with owner tracking, and interrupts raised from one core to another, acknowledged by the receiving core.

Arguments wider than the 16-bit field are taken from a write-data register. Software loads that register before it issues the command. One result register serves all commands, so software reads it after each command that returns data.

Top module: `cluster_cmd_port`

## Requirements
- R1: After reset, readback is 0, every interrupt line is low, the counter is 0 and no semaphore is held.
- R2: A write to address 0x600 is a command: opcode in bits 7:0, argument in bits 23:8, bits 31:24 ignored. A write to 0x601 loads write-data and leaves readback unchanged. Writes to any other address have no effect.
- R3: The 64-bit counter increments on every clock. Opcode 0x42 loads its low 32 bits into readback and 0x43 its high 32 bits. The value sampled is the one present at the clock edge that captures the command, and readback shows it after that edge.
- R4: Opcode 0x11 claims the semaphore indexed by the argument. Readback becomes 1 if it was free or already held by the requester, else 0. On success the requester becomes the owner. An index of NSEM or more returns 0.
- R5: Opcode 0x12 frees the indexed semaphore only when the requester owns it. It never changes readback.
- R6: Opcode 0x01 marks an interrupt pending from the requester at the target core named by the argument. irq_out of that target goes high after the second clock edge that follows the command. A target of NCORE or more is ignored.
- R7: Opcode 0x02 clears, at the requester, the interrupt pending from the source core named by the argument. If argument bit 15 is set, it instead clears every source whose bit is 1 in write-data. irq_out of a core falls once nothing is pending there.
- R8: Opcode 0x03 loads readback with the requester's pending mask: bit s is set when source s has an interrupt pending at the requester.
- R9: Opcode 0x04 loads readback with bit t set when an interrupt raised by the requester is still pending at core t.
- R10: Any other opcode has no effect and leaves readback unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 12 | Register address |
| bus_wdata | input | 32 | Write data (command word or write-data value) |
| bus_core | input | 2 | Number of the core issuing the write |
| rdback | output | 32 | Readback register |
| irq_out | output | 4 | Per-core interrupt lines, high while anything is pending |

## Verification
A corrupted owner field makes a claim return the wrong value on the readback of the very next command. A release that frees a semaphore for a non-owner shows the same way. Bad pending state is visible one cycle after a status or source query, and two edges after a raise or acknowledge on irq_out. A counter that skips or stalls shows as a wrong difference between two low-half reads a known number of cycles apart. A decoder that reacts to unknown opcodes or stray addresses shows as readback or semaphore state changing where it must hold.

// File: rtl/cmdp_pkg.sv
package cmdp_pkg;
  localparam int AUX_W = 12;
  localparam logic [AUX_W-1:0] ADR_CMD   = 12'h600;
  localparam logic [AUX_W-1:0] ADR_WDATA = 12'h601;

  localparam logic [7:0] OP_IRQ_RAISE = 8'h01;
  localparam logic [7:0] OP_IRQ_ACK   = 8'h02;
  localparam logic [7:0] OP_IRQ_STAT  = 8'h03;
  localparam logic [7:0] OP_IRQ_SRC   = 8'h04;
  localparam logic [7:0] OP_SEM_CLAIM = 8'h11;
  localparam logic [7:0] OP_SEM_FREE  = 8'h12;
  localparam logic [7:0] OP_CNT_LO    = 8'h42;
  localparam logic [7:0] OP_CNT_HI    = 8'h43;
endpackage

// File: rtl/cmdp_gcnt.sv
module cmdp_gcnt #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_q + 1'b1;
  end

  assign cnt = cnt_q;

  // R3: free-running, one step per clock
  p_cnt_step_r3: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/cmdp_sema.sv
module cmdp_sema #(
  parameter int NSEM   = 16,
  parameter int CORE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              claim_en,
  input  logic              free_en,
  input  logic [15:0]       arg,
  input  logic [CORE_W-1:0] core,
  output logic              grant
);
  localparam int IDX_W = (NSEM > 1) ? $clog2(NSEM) : 1;

  logic [NSEM-1:0]   held_q;
  logic [CORE_W-1:0] who_q [NSEM];
  logic              in_range;
  logic [IDX_W-1:0]  sel;

  assign in_range = (32'(arg) < NSEM);
  assign sel      = arg[IDX_W-1:0];
  assign grant    = in_range && (!held_q[sel] || who_q[sel] == core);

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q <= '0;
      for (int i = 0; i < NSEM; i++) who_q[i] <= '0;
    end else if (in_range) begin
      if (claim_en && grant) begin
        held_q[sel] <= 1'b1;
        who_q[sel]  <= core;
      end else if (free_en && held_q[sel] && who_q[sel] == core) begin
        held_q[sel] <= 1'b0;
      end
    end
  end

  for (genvar i = 0; i < NSEM; i++) begin : g_chk
    // R5: a semaphore is only freed by its owner
    p_sem_free_owner_r5: assert property (@(posedge clk) disable iff (rst)
      $fell(held_q[i]) |-> $past(free_en && 32'(arg) == i && who_q[i] == core));
    // R4: a held semaphore never changes hands
    p_sem_keep_owner_r4: assert property (@(posedge clk) disable iff (rst)
      held_q[i] && $past(held_q[i]) |-> who_q[i] == $past(who_q[i]));
  end
endmodule

// File: rtl/cmdp_xirq.sv
module cmdp_xirq #(
  parameter int NCORE  = 4,
  parameter int CORE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              raise_en,
  input  logic              ack_en,
  input  logic [15:0]       arg,
  input  logic [NCORE-1:0]  mask,
  input  logic [CORE_W-1:0] core,
  output logic [NCORE-1:0]  stat_vec,
  output logic [NCORE-1:0]  src_vec,
  output logic [NCORE-1:0]  irq
);
  // pend_q[target][source]
  logic [NCORE-1:0][NCORE-1:0] pend_q;
  logic [NCORE-1:0]            irq_q;
  logic                        arg_ok;

  assign arg_ok = (32'(arg) < NCORE);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      irq_q  <= '0;
    end else begin
      for (int t = 0; t < NCORE; t++) begin
        for (int s = 0; s < NCORE; s++) begin
          if (raise_en && arg_ok && arg[CORE_W-1:0] == CORE_W'(t) && core == CORE_W'(s))
            pend_q[t][s] <= 1'b1;
          else if (ack_en && core == CORE_W'(t) &&
                   (arg[15] ? mask[s] : (arg_ok && arg[CORE_W-1:0] == CORE_W'(s))))
            pend_q[t][s] <= 1'b0;
        end
        irq_q[t] <= |pend_q[t];
      end
    end
  end

  always_comb begin
    stat_vec = pend_q[core];
    for (int t = 0; t < NCORE; t++) src_vec[t] = pend_q[t][core];
  end

  assign irq = irq_q;

  for (genvar t = 0; t < NCORE; t++) begin : g_t
    for (genvar s = 0; s < NCORE; s++) begin : g_s
      // R6: a pending bit appears only on a raise from s aimed at t
      p_irq_set_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(pend_q[t][s]) |-> $past(raise_en && core == CORE_W'(s) && 32'(arg) == t));
      // R7: a pending bit clears only on an acknowledge by its target
      p_irq_clear_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(pend_q[t][s]) |-> $past(ack_en && core == CORE_W'(t)));
    end
  end
endmodule

// File: rtl/cluster_cmd_port.sv
module cluster_cmd_port
  import cmdp_pkg::*;
#(
  parameter int NCORE = 4,
  parameter int NSEM  = 16,
  parameter int DW    = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     bus_wr,
  input  logic [AUX_W-1:0]         bus_addr,
  input  logic [DW-1:0]            bus_wdata,
  input  logic [$clog2(NCORE)-1:0] bus_core,
  output logic [DW-1:0]            rdback,
  output logic [NCORE-1:0]         irq_out
);
  localparam int CORE_W = $clog2(NCORE);
  localparam int CNT_W  = 2 * DW;

  logic              is_cmd, is_wd, known;
  logic [7:0]        op;
  logic [15:0]       arg;
  logic [DW-1:0]     wd_q, rb_q, rb_d;
  logic [CNT_W-1:0]  cnt;
  logic              grant;
  logic [NCORE-1:0]  stat_vec, src_vec;

  assign is_cmd = bus_wr && bus_addr == ADR_CMD;
  assign is_wd  = bus_wr && bus_addr == ADR_WDATA;
  assign op     = bus_wdata[7:0];
  assign arg    = bus_wdata[23:8];
  assign known  = op inside {OP_IRQ_RAISE, OP_IRQ_ACK, OP_IRQ_STAT, OP_IRQ_SRC,
                             OP_SEM_CLAIM, OP_SEM_FREE, OP_CNT_LO, OP_CNT_HI};

  cmdp_gcnt #(.CNT_W(CNT_W)) u_cnt (.clk(clk), .rst(rst), .cnt(cnt));

  cmdp_sema #(.NSEM(NSEM), .CORE_W(CORE_W)) u_sem (
    .clk(clk), .rst(rst),
    .claim_en(is_cmd && op == OP_SEM_CLAIM),
    .free_en (is_cmd && op == OP_SEM_FREE),
    .arg(arg), .core(bus_core), .grant(grant));

  cmdp_xirq #(.NCORE(NCORE), .CORE_W(CORE_W)) u_irq (
    .clk(clk), .rst(rst),
    .raise_en(is_cmd && op == OP_IRQ_RAISE),
    .ack_en  (is_cmd && op == OP_IRQ_ACK),
    .arg(arg), .mask(wd_q[NCORE-1:0]), .core(bus_core),
    .stat_vec(stat_vec), .src_vec(src_vec), .irq(irq_out));

  always_comb begin
    rb_d = rb_q;
    if (is_cmd) begin
      case (op)
        OP_CNT_LO:    rb_d = cnt[DW-1:0];
        OP_CNT_HI:    rb_d = cnt[CNT_W-1:DW];
        OP_SEM_CLAIM: rb_d = DW'(grant);
        OP_IRQ_STAT:  rb_d = DW'(stat_vec);
        OP_IRQ_SRC:   rb_d = DW'(src_vec);
        default:      rb_d = rb_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rb_q <= '0;
      wd_q <= '0;
    end else begin
      rb_q <= rb_d;
      if (is_wd) wd_q <= bus_wdata;
    end
  end

  assign rdback = rb_q;

  // R10: unknown opcodes leave readback alone
  p_unknown_hold_r10: assert property (@(posedge clk) disable iff (rst)
    is_cmd && !known |=> $stable(rdback));
  // R4: a claim answers with a single bit
  p_claim_bool_r4: assert property (@(posedge clk) disable iff (rst)
    is_cmd && op == OP_SEM_CLAIM |=> rdback[DW-1:1] == '0);
  // R2: write-data loads never touch readback
  p_wdata_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    is_wd |=> $stable(rdback));
endmodule

// File: tb/cluster_cmd_port_test.sv
`timescale 1ns/1ps
module cluster_cmd_port_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [1:0]  bus_core = '0;
  logic [31:0] rdback;
  logic [3:0]  irq_out;

  int nchk = 0;
  int nerr = 0;
  logic exp_flag = 1'b0;
  bit done = 1'b0;

  typedef struct { logic [31:0] v; string tag; } exp_t;
  exp_t sb_q[$];

  always #2.5 clk = ~clk;

  cluster_cmd_port uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_core(bus_core), .rdback(rdback), .irq_out(irq_out));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // driver: called at a negedge, returns at the next negedge
  task automatic wr(logic [1:0] core, logic [11:0] addr, logic [31:0] data,
                    bit chk, logic [31:0] exp, string tag);
    exp_t e;
    bus_wr = 1'b1; bus_addr = addr; bus_wdata = data; bus_core = core;
    if (chk) begin
      e.v = exp; e.tag = tag;
      sb_q.push_back(e);
      exp_flag = 1'b1;
    end
    @(negedge clk);
    bus_wr = 1'b0; exp_flag = 1'b0;
  endtask

  task automatic cmd(logic [1:0] core, logic [7:0] op, logic [15:0] arg,
                     bit chk, logic [31:0] exp, string tag);
    wr(core, 12'h600, {8'h00, arg, op}, chk, exp, tag);
  endtask

  // monitor: compares readback half a cycle after the capturing edge
  initial begin
    forever begin
      @(posedge clk);
      if (exp_flag) begin
        exp_t e;
        @(negedge clk);
        e = sb_q.pop_front();
        check(e.tag, rdback, e.v);
      end
    end
  end

  initial begin
    #500000;
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    logic [31:0] v1, v2;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 readback after reset", rdback, 32'h0);
    check("R1 irq after reset", {28'h0, irq_out}, 32'h0);
    cmd(2'd0, 8'h43, 16'h0, 1, 32'h0, "R1 R3 counter high half zero");

    // R3: counter step between two low reads six cycles apart
    cmd(2'd0, 8'h42, 16'h0, 0, 0, "");
    v1 = rdback;
    repeat (5) @(negedge clk);
    cmd(2'd1, 8'h42, 16'h0, 0, 0, "");
    v2 = rdback;
    check("R3 counter low delta", v2 - v1, 32'd6);

    // R4 / R5 semaphores
    cmd(2'd1, 8'h11, 16'd3, 1, 32'd1, "R4 claim free");
    cmd(2'd2, 8'h11, 16'd3, 1, 32'd0, "R4 claim held by other");
    cmd(2'd1, 8'h11, 16'd3, 1, 32'd1, "R4 reclaim by owner");
    cmd(2'd2, 8'h12, 16'd3, 1, 32'd1, "R5 release keeps readback");
    cmd(2'd2, 8'h11, 16'd3, 1, 32'd0, "R5 non-owner release ignored");
    cmd(2'd1, 8'h12, 16'd3, 0, 0, "");
    cmd(2'd2, 8'h11, 16'd3, 1, 32'd1, "R5 owner release frees");
    cmd(2'd0, 8'h11, 16'd20, 1, 32'd0, "R4 index out of range");

    // R2: padding bits ignored, stray address ignored, write-data quiet
    wr(2'd0, 12'h600, 32'hAB000511, 1, 32'd1, "R2 padding ignored");
    wr(2'd0, 12'h605, 32'h00000711, 0, 0, "");
    cmd(2'd3, 8'h11, 16'd7, 1, 32'd1, "R2 stray address no claim");
    wr(2'd3, 12'h601, 32'h0000FFFF, 1, 32'd1, "R2 write-data keeps readback");

    // R6..R9 interrupts
    cmd(2'd0, 8'h01, 16'd2, 0, 0, "");
    check("R6 irq not yet", {28'h0, irq_out}, 32'h0);
    @(negedge clk);
    check("R6 irq raised at core 2", {28'h0, irq_out}, 32'h4);
    cmd(2'd2, 8'h03, 16'd0, 1, 32'h1, "R8 status one source");
    cmd(2'd0, 8'h04, 16'd0, 1, 32'h4, "R9 source pending at core 2");
    cmd(2'd1, 8'h01, 16'd2, 0, 0, "");
    cmd(2'd2, 8'h03, 16'd0, 1, 32'h3, "R8 status two sources");
    cmd(2'd2, 8'h02, 16'd0, 0, 0, "");
    cmd(2'd2, 8'h03, 16'd0, 1, 32'h2, "R7 single ack");
    cmd(2'd0, 8'h04, 16'd0, 1, 32'h0, "R9 source cleared");
    check("R7 irq held by remaining source", {28'h0, irq_out}, 32'h4);
    wr(2'd2, 12'h601, 32'h00000002, 0, 0, "");
    cmd(2'd2, 8'h02, 16'h8000, 0, 0, "");
    cmd(2'd2, 8'h03, 16'd0, 1, 32'h0, "R7 mask ack");
    check("R7 irq dropped", {28'h0, irq_out}, 32'h0);
    cmd(2'd1, 8'h01, 16'd9, 0, 0, "");
    @(negedge clk);
    check("R6 bad target ignored", {28'h0, irq_out}, 32'h0);

    // R10 unknown opcode
    cmd(2'd3, 8'h04, 16'd0, 0, 0, "");
    cmd(2'd1, 8'h01, 16'd3, 0, 0, "");
    cmd(2'd1, 8'h04, 16'd0, 1, 32'h8, "R9 source at core 3");
    cmd(2'd1, 8'h55, 16'd0, 1, 32'h8, "R10 unknown opcode holds readback");
    cmd(2'd1, 8'h13, 16'd3, 1, 32'h8, "R10 near-miss opcode holds readback");

    repeat (3) @(negedge clk);
    check("scoreboard drained", 32'(sb_q.size()), 32'd0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule